// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Edge Capture

This peripheral gives a host word-wide register access to a bank of up to 32 general-purpose pins. For each pin it keeps an output value, an output-enable (direction) bit, an interrupt enable bit and a sticky event bit. Input levels pass through a two-stage synchroniser before they are read back or examined for transitions. One interrupt line goes to the host.

The event that raises an interrupt is one build-time choice shared by every pin. In the three edge choices (rising, falling, either), a detected transition sets a sticky event bit that stays set until software writes a one to it. Enabled event bits are OR-reduced to form the interrupt. In the level choice no events are recorded, and the interrupt follows the synchronised pin levels gated by the enable bits. The pin count is a parameter: values above 32 are treated as 32, and lanes above the count are held at zero.

The bus is a single-cycle write strobe with a word index; read data is combinational from the word index.

Top module: `pin_bank_ctl`

## Requirements
- R1: The word index selects the register: 0 pin data, 1 direction, 2 interrupt enable, 3 event capture (byte offsets 0x0, 0x4, 0x8, 0xC).
- R2: The active pin count is PIN_COUNT clamped to 32; lanes at or above it read as zero, ignore writes, and drive zero on `pin_out` and `pin_oe`.
- R3: A direction bit of 1 asserts the matching `pin_oe` bit, which makes the pin an output; 0 makes it an input.
- R4: A write to word 0 sets `pin_out` from the next clock edge. A read of word 0 returns `pin_in` after two synchroniser stages: a change driven before edge k is visible after edge k+1.
- R5: In edge modes an event bit is set after the third clock edge following a qualifying pin change (rising 0 to 1, falling 1 to 0, either both), and is unchanged when no event and no clear occur; transitions of the other polarity do not set it.
- R6: Writing word 3 clears each event bit whose write-data bit is 1; bits written with 0 stay unchanged.
- R7: When a new event and a clearing write hit the same bit in the same cycle, the bit ends set.
- R8: In edge modes `irq` is high exactly while (event capture AND enable) is nonzero; an enable bit of 0 keeps that pin from raising `irq`.
- R9: In level mode `irq` is high while (synchronised pin levels AND enable) is nonzero, and the event register stays zero.
- R10: After reset every register, `pin_out`, `pin_oe` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word | input | 2 | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench aims at the synchroniser latency, counting edges so that a design with one stage too few or too many reads back the new level a cycle early or late. It drives a clearing write into exactly the cycle in which a new edge lands, which a design giving the clear priority would lose. It runs every trigger choice side by side, so a falling-edge instance that also caught rising edges, or a level instance that still recorded events, shows up. A small instance catches upper lanes that keep write data or capture edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int MAX_PINS = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam logic [1:0] WORD_DATA = 2'd0;
    localparam logic [1:0] WORD_DIR  = 2'd1;
    localparam logic [1:0] WORD_IEN  = 2'd2;
    localparam logic [1:0] WORD_EVT  = 2'd3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/edge_event.sv
module edge_event
    import gpio_pkg::*;
#(
    parameter int    W    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    generate
        if (TRIG == TRIG_RISE) begin : g_rise
            assign evt = lvl & ~prev;
        end else if (TRIG == TRIG_FALL) begin : g_fall
            assign evt = ~lvl & prev;
        end else begin : g_both
            assign evt = lvl ^ prev;
        end
    endgenerate
endmodule

// File: rtl/edge_capture.sv
module edge_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] cap_q
);
    logic [W-1:0] clr_vec;

    always_comb begin
        clr_vec = clr_en ? clr_bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_vec) | evt;
    end

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> (($past(evt) & ~cap_q) == '0)); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((clr_bits & ~evt) != '0)) |=> (($past(clr_bits) & ~$past(evt) & cap_q) == '0)); // R6

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && evt == '0) |=> $stable(cap_q)); // R5
endmodule

// File: rtl/pin_bank_ctl.sv
module pin_bank_ctl
    import gpio_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIG      = TRIG_RISE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_word,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [31:0]         pin_in,
    output logic [31:0]         pin_out,
    output logic [31:0]         pin_oe,
    output logic                irq
);
    localparam int          NPIN  = (PIN_COUNT > MAX_PINS) ? MAX_PINS : PIN_COUNT;
    localparam logic [31:0] VALID = {MAX_PINS{1'b1}} >> (MAX_PINS - NPIN);

    logic [31:0] sync_q;
    logic [31:0] pin_lvl;
    logic [31:0] evt_w;
    logic [31:0] cap_w;
    logic [31:0] out_q;
    logic [31:0] dir_q;
    logic [31:0] ien_q;
    logic        clr_en;

    pin_sync #(.W(MAX_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    assign pin_lvl = sync_q & VALID;

    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            assign evt_w = '0;
            assign irq   = |(pin_lvl & ien_q);

            AST_LEVEL_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
                cap_w == '0); // R9
        end else begin : g_edge
            logic [31:0] raw_evt;

            edge_event #(.W(MAX_PINS), .TRIG(TRIG)) u_evt (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (pin_lvl),
                .evt   (raw_evt)
            );

            assign evt_w = raw_evt & VALID;
            assign irq   = |(cap_w & ien_q);
        end
    endgenerate

    assign clr_en = bus_wr && (bus_word == WORD_EVT);

    edge_capture #(.W(MAX_PINS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_w),
        .clr_en   (clr_en),
        .clr_bits (bus_wdata),
        .cap_q    (cap_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            ien_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_word)
                WORD_DATA: out_q <= bus_wdata & VALID;
                WORD_DIR:  dir_q <= bus_wdata & VALID;
                WORD_IEN:  ien_q <= bus_wdata & VALID;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_word)
            WORD_DATA: bus_rdata = pin_lvl;
            WORD_DIR:  bus_rdata = dir_q;
            WORD_IEN:  bus_rdata = ien_q;
            default:   bus_rdata = cap_w;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out | pin_oe | cap_w) & ~VALID) == '0); // R2

    AST_IEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R8

    AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == WORD_DIR) |=> (pin_oe == ($past(bus_wdata) & VALID))); // R3
endmodule

// File: tb/sim_pin_bank_ctl.sv
module sim_pin_bank_ctl;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_word = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd0, rd1, rd2, rd3;
    logic [31:0] po0, po1, po2, po3;
    logic [31:0] oe0, oe1, oe2, oe3;
    logic        irq0, irq1, irq2, irq3;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    pin_bank_ctl #(.PIN_COUNT(32), .TRIG(TRIG_RISE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd0), .pin_in(pin_in), .pin_out(po0), .pin_oe(oe0), .irq(irq0));
    pin_bank_ctl #(.PIN_COUNT(12), .TRIG(TRIG_BOTH)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd1), .pin_in(pin_in), .pin_out(po1), .pin_oe(oe1), .irq(irq1));
    pin_bank_ctl #(.PIN_COUNT(8), .TRIG(TRIG_LEVEL)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd2), .pin_in(pin_in), .pin_out(po2), .pin_oe(oe2), .irq(irq2));
    pin_bank_ctl #(.PIN_COUNT(40), .TRIG(TRIG_FALL)) u3 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd3), .pin_in(pin_in), .pin_out(po3), .pin_oe(oe3), .irq(irq3));

    // word(2) | wdata(32) | expected view u0(32) | expected view u1(32)
    localparam logic [97:0] VEC [4] = '{
        {2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0FFF},
        {2'd2, 32'h0000_F0F1, 32'h0000_F0F1, 32'h0000_00F1},
        {2'd0, 32'h1234_5678, 32'h1234_5678, 32'h0000_0678},
        {2'd1, 32'h0000_A5A5, 32'h0000_A5A5, 32'h0000_05A5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_word = w; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic sel(input logic [1:0] w);
        bus_word = w;
        #2;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        // R10: reset state
        for (int w = 0; w < 4; w++) begin
            sel(w[1:0]);
            chk("R10 reset rdata", rd0, 32'h0);
        end
        chk("R10 reset pin_out", po0, 32'h0);
        chk("R10 reset pin_oe", oe0, 32'h0);
        chk("R10 reset irq", {31'h0, irq0}, 32'h0);

        // R1 R2 R3 R4: table walk of register writes
        for (int k = 0; k < 4; k++) begin
            logic [1:0]  w;
            logic [31:0] v0, v1;
            w = VEC[k][97:96];
            wr(w, VEC[k][95:64]);
            sel(w);
            v0 = (w == 2'd0) ? po0 : rd0;
            v1 = (w == 2'd0) ? po1 : rd1;
            chk("R1 R4 table view u0", v0, VEC[k][63:32]);
            chk("R2 table view u1", v1, VEC[k][31:0]);
        end
        chk("R3 pin_oe u0", oe0, 32'h0000_A5A5);
        chk("R2 clamp pin_oe u3", oe3, 32'h0000_A5A5);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);

        // R4: synchroniser latency
        @(negedge clk); pin_in = 32'h1;
        @(negedge clk); sel(2'd0);
        chk("R4 data after one edge", rd0, 32'h0);
        @(negedge clk); sel(2'd0);
        chk("R4 data after two edges", rd0, 32'h1);
        chk("R4 data u2", rd2, 32'h1);
        sel(2'd3);
        chk("R5 capture not yet set", rd0, 32'h0);
        @(negedge clk); sel(2'd3);
        chk("R5 rising captured u0", rd0, 32'h1);
        chk("R5 both captured u1", rd1, 32'h1);
        chk("R5 falling ignores rise u3", rd3, 32'h0);
        chk("R9 level no capture u2", rd2, 32'h0);
        chk("R8 masked irq u0", {31'h0, irq0}, 32'h0);

        // R8 R9: enable gating
        wr(2'd2, 32'h1);
        chk("R8 irq enabled u0", {31'h0, irq0}, 32'h1);
        chk("R9 level irq u2", {31'h0, irq2}, 32'h1);

        // R6: write-one-to-clear
        wr(2'd3, 32'h0);
        sel(2'd3);
        chk("R6 zero write keeps", rd0, 32'h1);
        wr(2'd3, 32'hFFFF_FFFF);
        sel(2'd3);
        chk("R6 one write clears", rd0, 32'h0);
        chk("R8 irq drops u0", {31'h0, irq0}, 32'h0);
        chk("R9 level irq stays u2", {31'h0, irq2}, 32'h1);

        // R5 R9: falling transition
        @(negedge clk); pin_in = 32'h0;
        wait_neg(3); sel(2'd3);
        chk("R5 rising ignores fall u0", rd0, 32'h0);
        chk("R5 both sees fall u1", rd1, 32'h1);
        chk("R5 falling captured u3", rd3, 32'h1);
        chk("R9 level irq drops u2", {31'h0, irq2}, 32'h0);

        // R7: edge and clear in the same cycle
        @(negedge clk); pin_in = 32'h1;
        @(negedge clk);
        @(negedge clk);
        bus_word = 2'd3; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        sel(2'd3);
        chk("R7 edge wins u0", rd0, 32'h1);
        chk("R7 edge wins u1", rd1, 32'h1);
        chk("R6 clear without edge u3", rd3, 32'h0);

        // R2: upper lanes
        @(negedge clk); pin_in = 32'hFFFF_FFFF;
        wait_neg(3); sel(2'd0);
        chk("R2 data upper zero u1", rd1, 32'h0000_0FFF);
        chk("R2 data upper zero u2", rd2, 32'h0000_00FF);
        chk("R2 data full u3", rd3, 32'hFFFF_FFFF);
        sel(2'd3);
        chk("R2 capture upper zero u1", rd1, 32'h0000_0FFF);
        chk("R5 capture all lanes u0", rd0, 32'hFFFF_FFFF);
        chk("R9 level capture zero u2", rd2, 32'h0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule